// File: doc/BRIEF.md
# Indirect-Access Network Controller Register File

This block is the host-visible register file of a DMA Ethernet controller. The host never addresses registers directly: it first writes a register number into an address port, and every following data-port read or write goes to that register until the address port is written again. Behind the ports sit a mixed command/status word, the init-block pointer halves, a bus-configuration word, a 64-bit multicast filter held as four words and a mode word that carries the promiscuous enable.

The command/status word (register 0) is the heart of the block. Its command bits latch on a written 1 and ignore a written 0. Each such write also produces a one-cycle command pulse to the DMA and MAC logic. Event inputs from that logic set sticky flags that the host clears by writing ones. The word also reports an error summary and an interrupt summary, and the summary drives the interrupt pin. A stop command takes priority over everything else in the word and returns the bus configuration to zero. All configuration registers are locked against writes while the controller is running.

Top module: `netctl_csr`

## Requirements
- R1: A write to the address port latches `wdata[3:0]` as the selected register number. Data-port reads (`rdata`) and writes go to that register until the next address-port write, so several data writes in a row all land in the same register.
- R2: In register 0, bit 0 (init), bit 1 (start) and bit 3 (transmit demand) are set by writing 1 and are unchanged by writing 0. Each written 1 raises the matching `cmd_*` output high for exactly the one cycle after the write. A write of all zeros gives no pulse.
- R3: Writing start clears the stop bit (bit 2) and sets transmitter-on (bit 4) and receiver-on (bit 5). Writing init clears the stop bit.
- R4: Any register-0 write with bit 2 (stop) set makes register 0 read exactly 0x0004, whatever else the write held and whatever events arrive in the same cycle. It pulses `cmd_stop` and gives no `cmd_init` or `cmd_start` pulse.
- R5: Event inputs set flags in register 0: init done to bit 8, tx done to bit 9, rx done to bit 10, memory error to bit 11, missed frame to bit 12, carrier error to bit 13 and babble to bit 14. Writing 1 to a flag clears it. Writing 0 leaves it. An event in the same cycle as a clearing write leaves the flag set.
- R6: Bit 15 of register 0 reads as the OR of bits 11 to 14, and writes to bit 15 have no effect.
- R7: Bit 6 is a plain read/write interrupt enable. Bit 7 and the `irq` output both equal bit 6 AND the OR of bits 8 to 14.
- R8: A stop command resets the bus-configuration register (register 3: bit 0 byte control, bit 1 address-latch control, bit 2 byte swap, 1 = big-endian) to 0.
- R9: Registers 1 and 2 (init-block address low and high), 3 (bus configuration, 3 bits), 8 to 11 (multicast filter, register 8 least significant) and 15 (only bit 15 is kept, promiscuous enable) accept writes only while the stop bit is 1. While running, writes to them are ignored and reads return the stored values.
- R10: Register numbers 4 to 7 and 12 to 14 read as 0, and writes to them change nothing.
- R11: After reset, register 0 reads 0x0004, every other register reads 0, `irq` is low and the selected register is 0.
- R12: The transmit-demand bit (bit 3) stays set until a tx-done event or a stop clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ap_wr | input | 1 | Address-port write strobe |
| dp_wr | input | 1 | Data-port write strobe |
| wdata | input | 16 | Write data for either port |
| rdata | output | 16 | Data-port read value of the selected register |
| ev_init_done | input | 1 | Initialization finished event |
| ev_tx_done | input | 1 | Transmit finished event |
| ev_rx_done | input | 1 | Receive finished event |
| ev_mem_err | input | 1 | Memory error event |
| ev_missed | input | 1 | Missed frame event |
| ev_carrier | input | 1 | Carrier error event |
| ev_babble | input | 1 | Babble event |
| cmd_init | output | 1 | Init command pulse |
| cmd_start | output | 1 | Start command pulse |
| cmd_stop | output | 1 | Stop command pulse |
| cmd_tdmd | output | 1 | Transmit-demand command pulse |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| irq | output | 1 | Interrupt request |
| init_addr | output | 32 | Init-block address {high, low} |
| bus_cfg | output | 3 | Bus configuration bits |
| mcast_filter | output | 64 | Multicast filter |
| promisc | output | 1 | Promiscuous mode enable |

## Verification
The interrupt properties assume that an interrupt-enabling write carries no clear bits for the flags that the events are setting. The stop-readback property assumes that the address port is not written in the same cycle as the stop. The bench drives the two ports in separate cycles and keeps each write separate from any event pulse. It breaks that rule once, on purpose, to show that a set beats a clear. The configuration-lock property holds whenever the controller is running, so the bench sweeps every register number with fresh data after a start to exercise it.

// File: rtl/netctl_csr_pkg.sv
`timescale 1ns/1ps
package netctl_csr_pkg;
  localparam int CSR_W  = 16;
  localparam int EVT_N  = 7;
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_TXON = 4;
  localparam int B_RXON = 5;
  localparam int B_INEA = 6;
  localparam int B_INTR = 7;
  localparam int B_EVT0 = 8;
  localparam int B_ESUM = 15;
  localparam int EVT_TX = 1;
  localparam int REG_MAIN    = 0;
  localparam int REG_IADR_LO = 1;
  localparam int REG_IADR_HI = 2;
  localparam int REG_BUSCFG  = 3;
  localparam int REG_MODE    = 15;
  localparam int BUSCFG_W    = 3;

  typedef struct packed {
    logic             init;
    logic             start;
    logic             stop;
    logic             tdmd;
    logic             txon;
    logic             rxon;
    logic             inten;
    logic [EVT_N-1:0] flags;
  } main_state_t;

  function automatic logic err_summary(input logic [EVT_N-1:0] f);
    return |f[EVT_N-1:3];
  endfunction

  function automatic logic irq_of(input logic inten, input logic [EVT_N-1:0] f);
    return inten & (|f);
  endfunction

  function automatic logic [CSR_W-1:0] pack_main(input main_state_t s);
    logic [CSR_W-1:0] v;
    v = '0;
    v[B_INIT] = s.init;
    v[B_STRT] = s.start;
    v[B_STOP] = s.stop;
    v[B_TDMD] = s.tdmd;
    v[B_TXON] = s.txon;
    v[B_RXON] = s.rxon;
    v[B_INEA] = s.inten;
    v[B_INTR] = irq_of(s.inten, s.flags);
    v[B_EVT0 +: EVT_N] = s.flags;
    v[B_ESUM] = err_summary(s.flags);
    return v;
  endfunction
endpackage

// File: rtl/netctl_csr_sel.sv
`timescale 1ns/1ps
module netctl_csr_sel #(
  parameter int REG_NUM_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ap_wr,
  input  logic [REG_NUM_W-1:0] num_in,
  output logic [REG_NUM_W-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (ap_wr) sel_q <= num_in;
  end
endmodule

// File: rtl/netctl_csr_main.sv
`timescale 1ns/1ps
module netctl_csr_main
  import netctl_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wdata,
  input  logic [EVT_N-1:0] evt_vec,
  output logic [CSR_W-1:0] csr_rd,
  output logic             cmd_init,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_tdmd,
  output logic             stopped,
  output logic             tx_on,
  output logic             rx_on,
  output logic             irq,
  output logic             stop_wr
);
  main_state_t      st_q, st_d;
  logic [EVT_N-1:0] w1c_mask;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[B_ESUM], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};
  assign stop_wr  = wr_en & wdata[B_STOP];
  assign w1c_mask = wr_en ? wdata[B_EVT0 +: EVT_N] : '0;

  always_comb begin
    st_d = st_q;
    if (stop_wr) begin
      st_d      = '0;
      st_d.stop = 1'b1;
    end else begin
      if (evt_vec[EVT_TX]) st_d.tdmd = 1'b0;
      st_d.flags = (st_q.flags & ~w1c_mask) | evt_vec;
      if (wr_en) begin
        if (wdata[B_INIT]) begin
          st_d.init = 1'b1;
          st_d.stop = 1'b0;
        end
        if (wdata[B_STRT]) begin
          st_d.start = 1'b1;
          st_d.stop  = 1'b0;
          st_d.txon  = 1'b1;
          st_d.rxon  = 1'b1;
        end
        if (wdata[B_TDMD]) st_d.tdmd = 1'b1;
        st_d.inten = wdata[B_INEA];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      st_q.stop <= 1'b1;
      cmd_init  <= 1'b0;
      cmd_start <= 1'b0;
      cmd_stop  <= 1'b0;
      cmd_tdmd  <= 1'b0;
    end else begin
      st_q      <= st_d;
      cmd_init  <= wr_en & wdata[B_INIT] & ~wdata[B_STOP];
      cmd_start <= wr_en & wdata[B_STRT] & ~wdata[B_STOP];
      cmd_stop  <= stop_wr;
      cmd_tdmd  <= wr_en & wdata[B_TDMD] & ~wdata[B_STOP];
    end
  end

  assign csr_rd  = pack_main(st_q);
  assign stopped = st_q.stop;
  assign tx_on   = st_q.txon;
  assign rx_on   = st_q.rxon;
  assign irq     = irq_of(st_q.inten, st_q.flags);
endmodule

// File: rtl/netctl_csr_cfg.sv
`timescale 1ns/1ps
module netctl_csr_cfg
  import netctl_csr_pkg::*;
#(
  parameter int REG_NUM_W  = 4,
  parameter int FILT_WORDS = 4,
  parameter int FILT_BASE  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [REG_NUM_W-1:0]        sel,
  input  logic [CSR_W-1:0]            wdata,
  input  logic                        stopped,
  input  logic                        stop_wr,
  output logic [CSR_W-1:0]            cfg_rd,
  output logic [2*CSR_W-1:0]          init_addr,
  output logic [BUSCFG_W-1:0]         bus_cfg,
  output logic [FILT_WORDS*CSR_W-1:0] mcast_filter,
  output logic                        promisc
);
  logic             wr_ok;
  logic [CSR_W-1:0] iadr_lo_q, iadr_hi_q;

  assign wr_ok = wr_en & stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iadr_lo_q <= '0;
      iadr_hi_q <= '0;
      bus_cfg   <= '0;
      promisc   <= 1'b0;
    end else begin
      if (wr_ok && int'(sel) == REG_IADR_LO) iadr_lo_q <= wdata;
      if (wr_ok && int'(sel) == REG_IADR_HI) iadr_hi_q <= wdata;
      if (stop_wr)                                 bus_cfg <= '0;
      else if (wr_ok && int'(sel) == REG_BUSCFG)   bus_cfg <= wdata[BUSCFG_W-1:0];
      if (wr_ok && int'(sel) == REG_MODE) promisc <= wdata[CSR_W-1];
    end
  end

  for (genvar g = 0; g < FILT_WORDS; g++) begin : g_filt
    localparam int RNUM = FILT_BASE + g;
    logic [CSR_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            word_q <= '0;
      else if (wr_ok && int'(sel) == RNUM)   word_q <= wdata;
    end
    assign mcast_filter[g*CSR_W +: CSR_W] = word_q;
  end

  assign init_addr = {iadr_hi_q, iadr_lo_q};

  always_comb begin
    cfg_rd = '0;
    if (int'(sel) == REG_IADR_LO) cfg_rd = iadr_lo_q;
    if (int'(sel) == REG_IADR_HI) cfg_rd = iadr_hi_q;
    if (int'(sel) == REG_BUSCFG)  cfg_rd = {{(CSR_W-BUSCFG_W){1'b0}}, bus_cfg};
    if (int'(sel) == REG_MODE)    cfg_rd = {promisc, {(CSR_W-1){1'b0}}};
    for (int i = 0; i < FILT_WORDS; i++)
      if (int'(sel) == FILT_BASE + i) cfg_rd = mcast_filter[i*CSR_W +: CSR_W];
  end
endmodule

// File: rtl/netctl_csr.sv
`timescale 1ns/1ps
module netctl_csr
  import netctl_csr_pkg::*;
#(
  parameter int REG_NUM_W  = 4,
  parameter int FILT_WORDS = 4,
  parameter int FILT_BASE  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ap_wr,
  input  logic                        dp_wr,
  input  logic [15:0]                 wdata,
  output logic [15:0]                 rdata,
  input  logic                        ev_init_done,
  input  logic                        ev_tx_done,
  input  logic                        ev_rx_done,
  input  logic                        ev_mem_err,
  input  logic                        ev_missed,
  input  logic                        ev_carrier,
  input  logic                        ev_babble,
  output logic                        cmd_init,
  output logic                        cmd_start,
  output logic                        cmd_stop,
  output logic                        cmd_tdmd,
  output logic                        tx_on,
  output logic                        rx_on,
  output logic                        irq,
  output logic [31:0]                 init_addr,
  output logic [2:0]                  bus_cfg,
  output logic [FILT_WORDS*16-1:0]    mcast_filter,
  output logic                        promisc
);
  logic [REG_NUM_W-1:0] sel_q;
  logic [EVT_N-1:0]     evt_vec;
  logic [CSR_W-1:0]     main_rd, cfg_rd;
  logic                 main_wr, stopped, stop_wr;

  assign evt_vec = {ev_babble, ev_carrier, ev_missed, ev_mem_err,
                    ev_rx_done, ev_tx_done, ev_init_done};
  assign main_wr = dp_wr & (int'(sel_q) == REG_MAIN);

  netctl_csr_sel #(.REG_NUM_W(REG_NUM_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .ap_wr(ap_wr),
    .num_in(wdata[REG_NUM_W-1:0]), .sel_q(sel_q)
  );

  netctl_csr_main u_main (
    .clk(clk), .rst_n(rst_n), .wr_en(main_wr), .wdata(wdata), .evt_vec(evt_vec),
    .csr_rd(main_rd), .cmd_init(cmd_init), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_tdmd(cmd_tdmd), .stopped(stopped),
    .tx_on(tx_on), .rx_on(rx_on), .irq(irq), .stop_wr(stop_wr)
  );

  netctl_csr_cfg #(.REG_NUM_W(REG_NUM_W), .FILT_WORDS(FILT_WORDS), .FILT_BASE(FILT_BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(dp_wr), .sel(sel_q), .wdata(wdata),
    .stopped(stopped), .stop_wr(stop_wr), .cfg_rd(cfg_rd),
    .init_addr(init_addr), .bus_cfg(bus_cfg), .mcast_filter(mcast_filter),
    .promisc(promisc)
  );

  assign rdata = (int'(sel_q) == REG_MAIN) ? main_rd : cfg_rd;
endmodule

// File: rtl/netctl_csr_chk.sv
`timescale 1ns/1ps
module netctl_csr_chk #(
  parameter int REG_NUM_W  = 4,
  parameter int FILT_WORDS = 4,
  parameter int FILT_BASE  = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ap_wr,
  input logic                        dp_wr,
  input logic [15:0]                 wdata,
  input logic [15:0]                 rdata,
  input logic [6:0]                  evt_vec,
  input logic                        cmd_init,
  input logic                        cmd_start,
  input logic                        cmd_stop,
  input logic                        irq,
  input logic [REG_NUM_W-1:0]        sel_q,
  input logic                        stopped,
  input logic [31:0]                 init_addr,
  input logic [2:0]                  bus_cfg,
  input logic [FILT_WORDS*16-1:0]    mcast_filter,
  input logic                        promisc
);
  logic sel0, main_stop_wr, unimpl;
  assign sel0         = (sel_q == '0);
  assign main_stop_wr = dp_wr && sel0 && wdata[2];
  assign unimpl       = !((int'(sel_q) <= 3) || (int'(sel_q) == 15) ||
                          ((int'(sel_q) >= FILT_BASE) && (int'(sel_q) < FILT_BASE + FILT_WORDS)));

  assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_wr |=> $stable(sel_q));

  assert_stop_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    main_stop_wr |=> (cmd_stop && !cmd_init && !cmd_start));

  assert_stop_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (main_stop_wr && !ap_wr) |=> (rdata == 16'h0004));

  assert_err_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel0 |-> (rdata[15] == (|rdata[14:11])));

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && sel0 && !wdata[2] && wdata[6] && (wdata[14:8] == 7'd0) && (|evt_vec)) |=> irq);

  assert_irq_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && sel0 && !wdata[6]) |=> !irq);

  assert_bus_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    main_stop_wr |=> (bus_cfg == 3'd0));

  assert_cfg_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !main_stop_wr) |=> ($stable(init_addr) && $stable(bus_cfg) &&
                                     $stable(mcast_filter) && $stable(promisc)));

  assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl |-> (rdata == 16'h0000));
endmodule

bind netctl_csr netctl_csr_chk #(.REG_NUM_W(REG_NUM_W), .FILT_WORDS(FILT_WORDS), .FILT_BASE(FILT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ap_wr(ap_wr), .dp_wr(dp_wr), .wdata(wdata), .rdata(rdata),
  .evt_vec(evt_vec), .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .irq(irq), .sel_q(sel_q), .stopped(stopped), .init_addr(init_addr), .bus_cfg(bus_cfg),
  .mcast_filter(mcast_filter), .promisc(promisc)
);

// File: tb/netctl_csr_test.sv
`timescale 1ns/1ps
module netctl_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ap_wr = 1'b0, dp_wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [6:0]  ev = '0;
  logic        cmd_init, cmd_start, cmd_stop, cmd_tdmd, tx_on, rx_on, irq, promisc;
  logic [31:0] init_addr;
  logic [2:0]  bus_cfg;
  logic [63:0] mcast_filter;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;
  logic [15:0] stored [16];

  always #2.5 clk = ~clk;

  netctl_csr uut (
    .clk(clk), .rst_n(rst_n), .ap_wr(ap_wr), .dp_wr(dp_wr), .wdata(wdata), .rdata(rdata),
    .ev_init_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_done(ev[2]), .ev_mem_err(ev[3]),
    .ev_missed(ev[4]), .ev_carrier(ev[5]), .ev_babble(ev[6]),
    .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_tdmd(cmd_tdmd),
    .tx_on(tx_on), .rx_on(rx_on), .irq(irq), .init_addr(init_addr), .bus_cfg(bus_cfg),
    .mcast_filter(mcast_filter), .promisc(promisc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int r);
    return 16'h5A5A ^ (16'(r) * 16'h0123);
  endfunction

  function automatic logic [15:0] rmask(input int r);
    if (r == 1 || r == 2 || (r >= 8 && r <= 11)) return 16'hFFFF;
    if (r == 3)  return 16'h0007;
    if (r == 15) return 16'h8000;
    return 16'h0000;
  endfunction

  // expected register 0: fl bit k maps to bit 8+k
  function automatic logic [15:0] mexp(input logic [6:0] ctl, input logic [6:0] fl);
    logic [15:0] v;
    v = {1'b0, fl, 1'b0, ctl};
    v[15] = |fl[6:3];
    v[7]  = ctl[6] & (|fl);
    return v;
  endfunction

  task automatic addr_wr(input int r);
    ap_wr = 1'b1; wdata = 16'(r);
    @(negedge clk); ap_wr = 1'b0;
  endtask

  task automatic data_wr(input logic [15:0] v);
    dp_wr = 1'b1; wdata = v;
    @(negedge clk); dp_wr = 1'b0;
  endtask

  task automatic pulse_ev(input int i);
    ev = 7'(1 << i);
    @(negedge clk); ev = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reg0", rdata, 16'h0004);
    chk("R11 irq", irq, 0);
    chk("R11 cfg outputs", {init_addr, bus_cfg, promisc}, 0);
    chk("R11 filter", mcast_filter, 0);

    // R9/R10 stopped sweep: every register number
    for (int r = 1; r < 16; r++) begin
      addr_wr(r); data_wr(pat(r));
      stored[r] = pat(r) & rmask(r);
    end
    for (int r = 1; r < 16; r++) begin
      addr_wr(r);
      chk($sformatf("R9 R10 stopped read reg %0d", r), rdata, stored[r]);
    end
    chk("R9 init_addr out", init_addr, {stored[2], stored[1]});
    chk("R9 bus_cfg out", bus_cfg, stored[3][2:0]);
    chk("R9 filter out", mcast_filter, {stored[11], stored[10], stored[9], stored[8]});
    addr_wr(15); data_wr(16'hFFFF); stored[15] = 16'h8000;
    chk("R9 promisc", {promisc, rdata}, {1'b1, 16'h8000});

    // R1 selection stays put across data writes
    addr_wr(1); data_wr(16'h1111); data_wr(16'h2222);
    stored[1] = 16'h2222;
    chk("R1 sticky select", rdata, 16'h2222);
    chk("R1 sticky output", init_addr[15:0], 16'h2222);

    // R2 zero write changes nothing
    addr_wr(0); data_wr(16'h0000);
    chk("R2 zero write pulses", {cmd_init, cmd_start, cmd_stop, cmd_tdmd}, 0);
    chk("R2 zero write value", rdata, 16'h0004);

    // R3 start
    data_wr(16'h0002);
    chk("R2 start pulse", {cmd_init, cmd_start, cmd_stop, cmd_tdmd}, 4'b0100);
    chk("R3 after start", rdata, 16'h0032);
    chk("R3 tx_on rx_on", {tx_on, rx_on}, 2'b11);
    @(negedge clk);
    chk("R2 start pulse one cycle", cmd_start, 0);

    // R9/R10 running sweep: writes ignored
    for (int r = 1; r < 16; r++) begin
      addr_wr(r); data_wr(~pat(r));
    end
    for (int r = 1; r < 16; r++) begin
      addr_wr(r);
      chk($sformatf("R9 R10 running read reg %0d", r), rdata, stored[r]);
    end
    chk("R9 running outputs", {init_addr, bus_cfg, promisc},
        {stored[2], stored[1], stored[3][2:0], 1'b1});

    // R5 R6 R7 each event with interrupts enabled
    addr_wr(0); data_wr(16'h0042);
    chk("R7 inten set", rdata, 16'h0072);
    for (int i = 0; i < 7; i++) begin
      pulse_ev(i);
      chk($sformatf("R5 R6 R7 event %0d read", i), rdata, mexp(7'h72, 7'(1 << i)));
      chk($sformatf("R7 event %0d irq", i), irq, 1);
      data_wr(16'(1 << (8 + i)) | 16'h0040);
      chk($sformatf("R5 event %0d cleared", i), {irq, rdata}, {1'b0, 16'h0072});
    end

    // R7 interrupt enable off, R6 write to bit 15 ignored
    data_wr(16'h8000);
    chk("R6 R7 inten off", {irq, rdata}, {1'b0, 16'h0032});
    pulse_ev(6);
    chk("R7 masked babble", {irq, rdata}, {1'b0, mexp(7'h32, 7'h40)});
    data_wr(16'h4000);
    chk("R5 babble cleared", rdata, 16'h0032);

    // R5 set wins over same-cycle clear
    dp_wr = 1'b1; wdata = 16'h0400; ev = 7'b0000100;
    @(negedge clk); dp_wr = 1'b0; ev = '0;
    chk("R5 set beats clear", rdata, 16'h0432);
    data_wr(16'h0400);
    chk("R5 rx cleared", rdata, 16'h0032);

    // R12 transmit demand
    data_wr(16'h0008);
    chk("R2 tdmd pulse", {cmd_init, cmd_start, cmd_stop, cmd_tdmd}, 4'b0001);
    chk("R12 tdmd held", rdata, 16'h003A);
    @(negedge clk);
    chk("R12 tdmd still held", rdata, 16'h003A);
    pulse_ev(1);
    chk("R12 tdmd cleared by tx done", rdata, 16'h0232);
    data_wr(16'h0200);

    // R4 R8 stop wins
    pulse_ev(3);
    data_wr(16'h0045);
    chk("R4 stop pulse only", {cmd_init, cmd_start, cmd_stop, cmd_tdmd}, 4'b0010);
    chk("R4 stop readback", rdata, 16'h0004);
    chk("R4 stop irq", {irq, tx_on, rx_on}, 0);
    chk("R8 bus cfg cleared", bus_cfg, 0);

    // R9 writable again while stopped
    addr_wr(3); data_wr(16'hFFFF);
    chk("R9 bus cfg after stop", rdata, 16'h0007);

    // R3 init clears stop
    addr_wr(0); data_wr(16'h0001);
    chk("R2 init pulse", {cmd_init, cmd_start, cmd_stop, cmd_tdmd}, 4'b1000);
    chk("R3 init clears stop", rdata, 16'h0001);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule